// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Selector

This block is the address-phase front end of a slave on a two-wire serial bus. It watches already synchronized copies of the clock line (SCL) and the data line (SDA). It detects bus start and stop conditions, shifts in address frames most significant bit first on rising SCL edges, and decides whether this device is being addressed. It can match either a 7-bit address or a two-frame 10-bit address, chosen by a mode input.

When a frame matches, the block pulls SDA low for the acknowledge clock. When the final address frame has been acknowledged, it raises a selection level and a one-cycle strobe, and it reports the transfer direction. A downstream data path uses these signals to take over the bus. Data bytes after the address phase pass by without any response from this block.

In 10-bit mode the block keeps a remembered-selection flag. A read is accepted only after a complete 10-bit write addressing, followed by a repeated start that carries the matching header with the read bit set.

The state machine has seven states:
- `ST_IDLE`: the bus is free.
- `ST_FIRST`: receiving the first address frame.
- `ST_SECOND`: receiving the low address byte in 10-bit mode.
- `ST_ACKW`: a frame matched; waiting for the SCL fall that ends bit 8.
- `ST_ACKD`: driving the acknowledge.
- `ST_SEL`: addressed; the data phase belongs to others.
- `ST_SKIP`: not addressed; waiting for the next start or stop.

Transitions:
- A stop from any state goes to `ST_IDLE`.
- A start from any state goes to `ST_FIRST`.
- A full frame in `ST_FIRST` or `ST_SECOND` goes to `ST_ACKW` on a match and to `ST_SKIP` otherwise.
- `ST_ACKW` goes to `ST_ACKD` on an SCL fall.
- `ST_ACKD` goes on an SCL fall to `ST_SEL` after a final frame, or to `ST_SECOND` after a 10-bit header frame.

Top module: `tw_addr_sel`

## Requirements
- R1: A start condition (SDA falling while SCL is high, including a repeated start) restarts address reception. `sel_o` and `sda_pull_o` are low from the following clock cycle.
- R2: A stop condition (SDA rising while SCL is high) clears `sel_o` and `sda_pull_o` and clears the remembered 10-bit selection.
- R3: With `ten_bit_i`=0, the first frame is 8 bits sampled on rising SCL edges, MSB first. Bits 7..1 are compared with `own_addr_i[6:0]` and bit 0 is the direction (0 write, 1 read). On a match the frame is acknowledged and `rd_o` equals the direction bit.
- R4: After a frame that is not acknowledged, or after selection, every later frame up to the next start or stop gets no acknowledge, even one that equals the own address. A frame that was not acknowledged leaves `sel_o` low.
- R5: `sda_pull_o` goes high in the clock cycle after the SCL falling edge that ends bit 8 of a matching frame. It goes low in the clock cycle after the next SCL falling edge.
- R6: With `ten_bit_i`=1, the first frame must be `11110`, then `own_addr_i[9:8]`, then direction 0, to be acknowledged without selecting. A following second frame equal to `own_addr_i[7:0]` is acknowledged and selects the device for a write. A first frame without that header is not acknowledged.
- R7: A second 10-bit frame that differs from `own_addr_i[7:0]` is not acknowledged, leaves the device unselected, and clears the remembered 10-bit selection.
- R8: A 10-bit first frame with the matching header and direction 1 is acknowledged, and selects the device for a read, only while the remembered 10-bit selection is set. Otherwise it is not acknowledged.
- R9: In 10-bit mode, a first frame whose header or high address bits do not match clears the remembered 10-bit selection.
- R10: `sel_stb_o` is a single-cycle pulse. It rises together with `sel_o` and `sda_pull_o` at the start of the final address acknowledge. `sel_o` then stays high until the next start or stop, and `rd_o` is low whenever `sel_o` is low.
- R11: After reset, `sda_pull_o`, `sel_o`, `sel_stb_o` and `rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (wired bus level) |
| own_addr_i | input | 10 | Own address; bits 6..0 used in 7-bit mode |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| sda_pull_o | output | 1 | Enable for the SDA pull-down driver |
| sel_o | output | 1 | Device is addressed for the current transfer |
| sel_stb_o | output | 1 | One-cycle pulse when selection begins |
| rd_o | output | 1 | Selected direction, 1 for read |

## Verification
The hardest state to reach from the ports is a 10-bit read selection, because it depends on memory carried across a repeated start. The bench gets there with full write addressing (header frame, then low byte), then a repeated start and the read header. Directed sequences then attack the flag from each side: a stop in between, a mismatching header after the repeated start, and a wrong low byte. Random transactions mix modes, addresses, directions and optional repeated reads against a bench model of the flag.

// File: rtl/tw_addr_pkg.sv
package tw_addr_pkg;

    localparam int TW_FRAME_BITS = 8;
    localparam int TW_ADDR_W     = 10;
    localparam int TW_HDR_W      = 5;
    localparam logic [TW_HDR_W-1:0] TW_HDR10 = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_ACKW,
        ST_ACKD,
        ST_SEL,
        ST_SKIP
    } tw_state_e;

endpackage

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic scl_q;
    logic sda_q;

    // Idle bus is high on both lines, so history resets high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign start_o = scl_i && scl_q && sda_q && !sda_i;
    assign stop_o  = scl_i && scl_q && !sda_q && sda_i;
    assign rise_o  = scl_i && !scl_q;
    assign fall_o  = !scl_i && scl_q;

endmodule

// File: rtl/tw_frame_shift.sv
module tw_frame_shift #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  rise_i,
    input  logic                  sda_i,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  full_o
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] sr_q;

    // Counter saturates at a full frame; the acknowledge clock is not shifted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (rise_i && (cnt_q != CNT_FULL)) begin
            sr_q  <= {sr_q[FRAME_BITS-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame_o = sr_q;
    assign full_o  = (cnt_q == CNT_FULL);

endmodule

// File: rtl/tw_addr_cmp.sv
module tw_addr_cmp
    import tw_addr_pkg::*;
#(
    parameter int FRAME_BITS = TW_FRAME_BITS,
    parameter int ADDR_W     = TW_ADDR_W
) (
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic [ADDR_W-1:0]     own_i,
    input  logic                  ten_bit_i,
    input  logic                  second_i,
    input  logic                  mem_i,
    output logic                  hit_o,
    output logic                  final_o,
    output logic                  rd_o,
    output logic                  mem_o
);

    localparam int SHORT_W = FRAME_BITS - 1;
    localparam int HIGH_W  = ADDR_W - FRAME_BITS;

    logic hdr_ok;
    logic dir_bit;

    assign dir_bit = frame_i[0];
    assign hdr_ok  = (frame_i[FRAME_BITS-1 -: TW_HDR_W] == TW_HDR10) &&
                     (frame_i[HIGH_W:1] == own_i[ADDR_W-1:FRAME_BITS]);

    always_comb begin
        hit_o   = 1'b0;
        final_o = 1'b1;
        rd_o    = 1'b0;
        mem_o   = mem_i;
        if (!ten_bit_i) begin
            hit_o = (frame_i[FRAME_BITS-1:1] == own_i[SHORT_W-1:0]);
            rd_o  = dir_bit;
        end else if (second_i) begin
            hit_o = (frame_i == own_i[FRAME_BITS-1:0]);
            mem_o = hit_o;
        end else if (hdr_ok) begin
            if (!dir_bit) begin
                hit_o   = 1'b1;
                final_o = 1'b0;
            end else begin
                hit_o = mem_i;
                rd_o  = 1'b1;
            end
        end else begin
            mem_o = 1'b0;
        end
    end

endmodule

// File: rtl/tw_addr_fsm.sv
module tw_addr_fsm
    import tw_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic fall_i,
    input  logic full_i,
    input  logic hit_i,
    input  logic final_i,
    input  logic rd_i,
    input  logic mem_nx_i,
    output logic second_o,
    output logic mem_o,
    output logic clr_o,
    output logic pull_o,
    output logic sel_o,
    output logic stb_o,
    output logic rd_o
);

    tw_state_e st_q, st_d;
    logic fin_q, fin_d;
    logic dir_q, dir_d;
    logic mem_q, mem_d;
    logic pull_q, sel_q, stb_q, rd_q;
    logic sel_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            fin_q <= 1'b0;
            dir_q <= 1'b0;
            mem_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            fin_q <= fin_d;
            dir_q <= dir_d;
            mem_q <= mem_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        fin_d = fin_q;
        dir_d = dir_q;
        mem_d = mem_q;
        clr_o = 1'b0;
        if (stop_i) begin
            st_d  = ST_IDLE;
            mem_d = 1'b0;
            clr_o = 1'b1;
        end else if (start_i) begin
            st_d  = ST_FIRST;
            clr_o = 1'b1;
        end else begin
            unique case (st_q)
                ST_FIRST, ST_SECOND: begin
                    if (full_i) begin
                        mem_d = mem_nx_i;
                        if (hit_i) begin
                            st_d  = ST_ACKW;
                            fin_d = final_i;
                            dir_d = rd_i;
                        end else begin
                            st_d = ST_SKIP;
                        end
                    end
                end
                ST_ACKW: begin
                    if (fall_i) begin
                        st_d = ST_ACKD;
                    end
                end
                ST_ACKD: begin
                    if (fall_i) begin
                        if (fin_q) begin
                            st_d = ST_SEL;
                        end else begin
                            st_d  = ST_SECOND;
                            clr_o = 1'b1;
                        end
                    end
                end
                ST_IDLE, ST_SEL, ST_SKIP: begin
                    st_d = st_q;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign sel_d = ((st_d == ST_ACKD) && fin_d) || (st_d == ST_SEL);

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q <= 1'b0;
            sel_q  <= 1'b0;
            stb_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            pull_q <= (st_d == ST_ACKD);
            sel_q  <= sel_d;
            stb_q  <= (st_d == ST_ACKD) && (st_q == ST_ACKW) && fin_d;
            rd_q   <= sel_d && dir_d;
        end
    end

    assign second_o = (st_q == ST_SECOND);
    assign mem_o    = mem_q;
    assign pull_o   = pull_q;
    assign sel_o    = sel_q;
    assign stb_o    = stb_q;
    assign rd_o     = rd_q;

endmodule

// File: rtl/tw_addr_sel.sv
module tw_addr_sel
    import tw_addr_pkg::*;
#(
    parameter int FRAME_BITS = TW_FRAME_BITS,
    parameter int ADDR_W     = TW_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    output logic              sda_pull_o,
    output logic              sel_o,
    output logic              sel_stb_o,
    output logic              rd_o
);

    logic start_w, stop_w, rise_w, fall_w;
    logic fsm_clr, shift_clr, full_w;
    logic [FRAME_BITS-1:0] frame_w;
    logic hit_w, final_w, rdsel_w, mem_nx_w;
    logic second_w, mem_w;

    tw_bus_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start_w),
        .stop_o  (stop_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    assign shift_clr = fsm_clr;

    tw_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (shift_clr),
        .rise_i  (rise_w),
        .sda_i   (sda_i),
        .frame_o (frame_w),
        .full_o  (full_w)
    );

    tw_addr_cmp #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W)) u_cmp (
        .frame_i   (frame_w),
        .own_i     (own_addr_i),
        .ten_bit_i (ten_bit_i),
        .second_i  (second_w),
        .mem_i     (mem_w),
        .hit_o     (hit_w),
        .final_o   (final_w),
        .rd_o      (rdsel_w),
        .mem_o     (mem_nx_w)
    );

    tw_addr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .stop_i   (stop_w),
        .fall_i   (fall_w),
        .full_i   (full_w),
        .hit_i    (hit_w),
        .final_i  (final_w),
        .rd_i     (rdsel_w),
        .mem_nx_i (mem_nx_w),
        .second_o (second_w),
        .mem_o    (mem_w),
        .clr_o    (fsm_clr),
        .pull_o   (sda_pull_o),
        .sel_o    (sel_o),
        .stb_o    (sel_stb_o),
        .rd_o     (rd_o)
    );

endmodule

// File: rtl/tw_addr_sel_chk.sv
module tw_addr_sel_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_pull_o,
    input logic sel_o,
    input logic sel_stb_o,
    input logic rd_o
);

    logic scl_h, sda_h;
    logic start_c, stop_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_h <= 1'b1;
            sda_h <= 1'b1;
        end else begin
            scl_h <= scl_i;
            sda_h <= sda_i;
        end
    end

    assign start_c = scl_i && scl_h && sda_h && !sda_i;
    assign stop_c  = scl_i && scl_h && !sda_h && sda_i;

    // R1
    start_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> !sel_o && !sda_pull_o);

    // R2
    stop_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !sel_o && !sda_pull_o);

    // R5
    pull_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !$past(scl_i) && $past(scl_i, 2));

    // R5
    pull_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) && !$past(stop_c) && !$past(start_c) |-> !$past(scl_i) && $past(scl_i, 2));

    // R10
    stb_with_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb_o |-> sel_o && sda_pull_o);

    // R10
    sel_rise_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> sel_stb_o);

    // R10
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb_o |=> !sel_stb_o);

    // R10
    rd_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o |-> !rd_o);

    // R3
    rd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o && $past(sel_o) |-> $stable(rd_o));

endmodule

bind tw_addr_sel tw_addr_sel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_pull_o (sda_pull_o),
    .sel_o      (sel_o),
    .sel_stb_o  (sel_stb_o),
    .rd_o       (rd_o)
);

// File: tb/tw_addr_sel_bench.sv
module tw_addr_sel_bench;

    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic [9:0] own = '0;
    logic       ten = 1'b0;
    logic       sda_pull_o, sel_o, sel_stb_o, rd_o;
    wire        sda_bus = msda & ~sda_pull_o;

    int  n_chk = 0;
    int  n_fail = 0;
    int  stb_cnt = 0;
    bit  done = 1'b0;
    bit  mem_m = 1'b0;
    bit  sel_m = 1'b0;
    bit  rd_m = 1'b0;
    int  phase = 0;
    int unsigned seed_dummy;

    always #2 clk = ~clk;

    tw_addr_sel u_tw_addr_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .own_addr_i (own),
        .ten_bit_i  (ten),
        .sda_pull_o (sda_pull_o),
        .sel_o      (sel_o),
        .sel_stb_o  (sel_stb_o),
        .rd_o       (rd_o)
    );

    always @(posedge clk) if (rst_n && sel_stb_o) stb_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        msda = 1'b1; wait_n(H);
        scl = 1'b1;  wait_n(H);
        msda = 1'b0; wait_n(H);
        scl = 1'b0;  wait_n(H);
        phase = 0; sel_m = 1'b0; rd_m = 1'b0;
        chk(!sel_o && !sda_pull_o, "R1 start deselects", {sel_o, sda_pull_o}, 0);
    endtask

    task automatic do_stop();
        msda = 1'b0; wait_n(H);
        scl = 1'b1;  wait_n(H);
        msda = 1'b1; wait_n(H);
        phase = 0; sel_m = 1'b0; rd_m = 1'b0; mem_m = 1'b0;
        chk(!sel_o && !sda_pull_o, "R2 stop deselects", {sel_o, sda_pull_o}, 0);
    endtask

    // Expected response from the requirements; updates the bench model.
    task automatic model(input [7:0] f, output bit a, output bit fin, output string tag);
        a = 1'b0; fin = 1'b1; tag = "R4";
        if (phase == 2) return;
        if (!ten) begin
            tag = "R3";
            a = (f[7:1] == own[6:0]);
            rd_m = f[0];
        end else if (phase == 1) begin
            tag = (f == own[7:0]) ? "R6" : "R7";
            a = (f == own[7:0]);
            rd_m = 1'b0;
            mem_m = a;
        end else if (f[7:3] == 5'b11110 && f[2:1] == own[9:8]) begin
            if (!f[0]) begin
                tag = "R6"; a = 1'b1; fin = 1'b0;
            end else begin
                tag = "R8"; a = mem_m; rd_m = 1'b1;
            end
        end else begin
            tag = "R9"; mem_m = 1'b0;
        end
        if (!a) phase = 2;
        else if (!fin) phase = 1;
        else begin phase = 2; sel_m = 1'b1; end
        if (!sel_m) rd_m = 1'b0;
    endtask

    task automatic frame(input [7:0] f);
        bit a, fin, got;
        string tag;
        int s0;
        s0 = stb_cnt;
        model(f, a, fin, tag);
        for (int i = 7; i >= 0; i--) begin
            msda = f[i]; wait_n(H);
            scl = 1'b1;  wait_n(H);
            scl = 1'b0;
        end
        chk(sda_pull_o == 1'b0, "R5 no pull before fall", sda_pull_o, 0);
        wait_n(1);
        chk(sda_pull_o == a, {tag, " R5 pull after bit 8 fall"}, sda_pull_o, a);
        msda = 1'b1; wait_n(H - 1);
        scl = 1'b1;  wait_n(H);
        got = !sda_bus;
        chk(got == a, {tag, " acknowledge"}, got, a);
        scl = 1'b0;
        chk(sda_pull_o == a, "R5 pull held to fall", sda_pull_o, a);
        wait_n(1);
        chk(sda_pull_o == 1'b0, "R5 pull released", sda_pull_o, 0);
        wait_n(H - 1);
        chk(sel_o == sel_m, {tag, " R10 sel level"}, sel_o, sel_m);
        chk(rd_o == (sel_m && rd_m), {tag, " R10 direction"}, rd_o, sel_m && rd_m);
        chk((stb_cnt - s0) == ((a && fin) ? 1 : 0), "R10 strobe count", stb_cnt - s0, (a && fin) ? 1 : 0);
    endtask

    function automatic [7:0] hdr(input bit rd);
        return {5'b11110, own[9:8], rd};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        seed_dummy = $urandom(32'h1C2B3A);
        wait_n(5);
        chk(!sda_pull_o && !sel_o && !sel_stb_o && !rd_o, "R11 reset outputs",
            {sda_pull_o, sel_o, sel_stb_o, rd_o}, 0);
        rst_n = 1'b1;
        wait_n(3);

        // 7-bit write and read
        ten = 1'b0; own = 10'h05A;
        do_start(); frame({7'h5A, 1'b0}); frame(8'h33); do_stop();
        do_start(); frame({7'h5A, 1'b1}); do_stop();
        // R4: mismatch, then own address ignored until start
        do_start(); frame({7'h5B, 1'b0}); frame({7'h5A, 1'b0});
        do_start(); frame({7'h5A, 1'b0}); do_stop();

        // 10-bit write then repeated-start read (R6, R8)
        ten = 1'b1; own = 10'h2DA;
        do_start(); frame(hdr(1'b0)); frame(8'hDA);
        do_start(); frame(hdr(1'b1)); do_stop();
        // R8/R2: memory cleared by stop
        do_start(); frame(hdr(1'b1)); do_stop();
        // R9: header mismatch after repeated start clears memory
        do_start(); frame(hdr(1'b0)); frame(8'hDA);
        do_start(); frame({5'b11110, 2'b01, 1'b0});
        do_start(); frame(hdr(1'b1)); do_stop();
        // R7: wrong low byte
        do_start(); frame(hdr(1'b0)); frame(8'hDB);
        do_start(); frame(hdr(1'b1)); do_stop();
        // R6: 7-bit style frame in 10-bit mode is rejected
        do_start(); frame({own[6:0], 1'b0}); do_stop();

        // random transactions
        for (int t = 0; t < 40; t++) begin
            ten = $urandom_range(0, 1);
            own = 10'($urandom);
            do_start();
            if (!ten) begin
                frame($urandom_range(0, 1) ? {own[6:0], 1'($urandom)} : 8'($urandom));
                if ($urandom_range(0, 1)) frame(8'($urandom));
            end else begin
                frame($urandom_range(0, 3) != 0 ? hdr(1'b0) : 8'($urandom));
                if (phase == 1) frame($urandom_range(0, 3) != 0 ? own[7:0] : 8'($urandom));
                if ($urandom_range(0, 1)) begin
                    do_start();
                    frame($urandom_range(0, 3) != 0 ? hdr(1'b1) : {5'b11110, 2'($urandom), 1'b1});
                end
            end
            do_stop();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule